// File: doc/BRIEF.md
# Pattern-Driven Self-Test Wrapper

This block wraps a small 4-in/4-out combinational logic cone and lets it check itself without outside test equipment. In normal operation the functional inputs pass through the cone to the functional outputs. When a test is requested, a sequencer switches an input multiplexer over to a 4-bit maximal-length linear feedback shift register. That register steps to a new pattern on every clock. On each pattern cycle, the cone's response is compared with a second copy of the same logic that serves as the golden reference.

A run covers all fifteen nonzero patterns exactly once. When it ends, the wrapper raises a completion flag and returns the multiplexer to normal operation. Any disagreement between the cone and the reference during the run sets a sticky failure flag. A manufacturing defect is modelled by a stuck-at overlay on the cone's outputs. The overlay is chosen through parameters and is off by default.

Top module: `bist_wrapper`

## Requirements
- R1: While reset (rstN low) is applied and just after it is released, doneFlag and failFlag are 0 and the wrapper is in normal mode.
- R2: In normal mode, dataOut = F(dataIn), where bit i of F(x) is x[i] XOR (x[(i+1) mod 4] AND x[(i+2) mod 4]).
- R3: A startReq sampled high while idle starts a run. Starting with the next cycle, the cone takes its input from the pattern register and dataIn has no effect on dataOut. The first pattern is 4'b0001.
- R4: On every run cycle the pattern p advances to {p[2:0], p[3]^p[2]}. Over a run it visits all 15 nonzero values and is never zero.
- R5: A run lasts exactly 15 pattern cycles. In the cycle after the last one, doneFlag is 1 and dataOut again follows F(dataIn).
- R6: A fault-free cone never raises failFlag. A cone whose outputs differ from the reference on any pattern raises failFlag.
- R7: failFlag stays set until reset or until a new run is accepted. Accepting a new run also clears doneFlag.
- R8: A startReq during a run is ignored: the pattern sequence and the run length are unchanged.
- R9: failFlag rises in the cycle after the first pattern cycle that shows a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request to begin a self-test run |
| dataIn | input | 4 | Functional inputs of the logic cone |
| dataOut | output | 4 | Outputs of the logic cone |
| doneFlag | output | 1 | Set when a run has completed |
| failFlag | output | 1 | Sticky mismatch indicator |

## Verification
A pattern register that stepped wrongly or started from the wrong seed would show up on dataOut during the first or second run cycle, because the cone's response is observed directly at the port. A run counter that was off by one would move the doneFlag rise and the return to normal mode by one cycle, and that cycle is sampled exactly. A comparator or sticky-flag fault shows in one of two ways: a stuck-at variant whose failFlag does not rise exactly two cycles into the run, or a flag that clears during idle cycles or fails to clear when a new run is accepted.

// File: rtl/bist_pkg.sv
package bist_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic testMode;  // cone input taken from pattern register
    logic loadSeed;  // reload pattern register with its seed
    logic step;      // advance pattern register
    logic clrFail;   // clear the sticky mismatch flag
  } bist_strobe_t;
endpackage

// File: rtl/bist_cut.sv
module bist_cut #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = x[i] ^ (x[(i+1)%W] & x[(i+2)%W]);
  end
endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_pkg::*;
#(
  parameter int PAT_W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  output bist_strobe_t strb,
  output logic         doneFlag
);
  localparam int RUN_LEN = (1 << PAT_W) - 1;
  localparam int CNT_W   = $clog2(RUN_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             accept, lastPat;

  assign accept  = (state == S_IDLE) && startReq;
  assign lastPat = (state == S_RUN) && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      doneFlag <= 1'b0;
    end else if (accept) begin
      state    <= S_RUN;
      cnt      <= '0;
      doneFlag <= 1'b0;
    end else if (state == S_RUN) begin
      if (lastPat) begin
        state    <= S_IDLE;
        doneFlag <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.testMode = (state == S_RUN);
    strb.step     = (state == S_RUN);
    strb.loadSeed = accept;
    strb.clrFail  = accept;
  end

  // R8: a run, once started, keeps counting regardless of startReq
  a_r8_run_continues: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && cnt != LAST) |=> (state == S_RUN && cnt == $past(cnt) + 1'b1));

  // R5: the last pattern cycle is followed by idle with done set
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    lastPat |=> (state == S_IDLE && doneFlag));
endmodule

// File: rtl/bist_datapath.sv
module bist_datapath
  import bist_pkg::*;
#(
  parameter int             PAT_W      = 4,
  parameter logic [PAT_W-1:0] SEED     = 1,
  parameter int             TAP_HI     = PAT_W - 1,
  parameter int             TAP_LO     = PAT_W - 2,
  parameter logic [PAT_W-1:0] STUCK_MASK = '0,
  parameter logic [PAT_W-1:0] STUCK_VAL  = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  bist_strobe_t     strb,
  input  logic [PAT_W-1:0] dataIn,
  output logic [PAT_W-1:0] dataOut,
  output logic             failFlag
);
  logic [PAT_W-1:0] pattern, cutIn, cutRaw, cutOut, goldOut;
  logic             feedback, mismatch;

  assign feedback = pattern[TAP_HI] ^ pattern[TAP_LO];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pattern <= SEED;
    else if (strb.loadSeed) pattern <= SEED;
    else if (strb.step)     pattern <= {pattern[PAT_W-2:0], feedback};
  end

  assign cutIn = strb.testMode ? pattern : dataIn;

  bist_cut #(.W(PAT_W)) i_cone (.x(cutIn),   .y(cutRaw));
  bist_cut #(.W(PAT_W)) i_gold (.x(pattern), .y(goldOut));

  // Stuck-at defect overlay on the cone under test
  assign cutOut   = (cutRaw & ~STUCK_MASK) | (STUCK_VAL & STUCK_MASK);
  assign dataOut  = cutOut;
  assign mismatch = strb.testMode && (cutOut != goldOut);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             failFlag <= 1'b0;
    else if (strb.clrFail) failFlag <= 1'b0;
    else if (mismatch)     failFlag <= 1'b1;
  end

  // R4: the pattern register never reaches the lock-up state
  a_r4_pattern_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    pattern != '0);

  // R7: once set, failFlag holds until a new run is accepted
  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !strb.clrFail) |=> failFlag);

  // R9: failFlag only rises after a mismatching pattern cycle
  a_r9_fail_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> $past(mismatch));
endmodule

// File: rtl/bist_wrapper.sv
module bist_wrapper
  import bist_pkg::*;
#(
  parameter int               PAT_W      = 4,
  parameter logic [PAT_W-1:0] SEED       = 1,
  parameter logic [PAT_W-1:0] STUCK_MASK = '0,
  parameter logic [PAT_W-1:0] STUCK_VAL  = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [PAT_W-1:0] dataIn,
  output logic [PAT_W-1:0] dataOut,
  output logic             doneFlag,
  output logic             failFlag
);
  bist_strobe_t strb;

  bist_ctrl #(.PAT_W(PAT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .strb(strb), .doneFlag(doneFlag)
  );

  bist_datapath #(
    .PAT_W(PAT_W), .SEED(SEED), .TAP_HI(PAT_W - 1), .TAP_LO(PAT_W - 2),
    .STUCK_MASK(STUCK_MASK), .STUCK_VAL(STUCK_VAL)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dataIn(dataIn), .dataOut(dataOut), .failFlag(failFlag)
  );
endmodule

// File: tb/test_bist_wrapper.sv
module test_bist_wrapper;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [3:0] dataIn = 4'd0;
  logic [3:0] dataOut, dataOutF;
  logic       doneFlag, failFlag, doneF, failF;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct { logic [3:0] val; string tag; } exp_t;
  exp_t expQ[$];

  always #(CLK_P/2) clk = ~clk;

  bist_wrapper i_bist_wrapper (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dataIn(dataIn),
    .dataOut(dataOut), .doneFlag(doneFlag), .failFlag(failFlag)
  );

  // Same wrapper with output bit 0 stuck at 1
  bist_wrapper #(.STUCK_MASK(4'b0001), .STUCK_VAL(4'b0001)) i_bist_wrapper_flt (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dataIn(dataIn),
    .dataOut(dataOutF), .doneFlag(doneF), .failFlag(failF)
  );

  function automatic logic [3:0] refF(input logic [3:0] x);
    for (int i = 0; i < 4; i++) refF[i] = x[i] ^ (x[(i+1)%4] & x[(i+2)%4]);
  endfunction

  function automatic logic [3:0] refNext(input logic [3:0] p);
    return {p[2:0], p[3] ^ p[2]};
  endfunction

  task automatic checkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: set inputs just after an edge, push the expected dataOut
  task automatic drive(input logic [3:0] din, input logic st,
                       input logic [3:0] expOut, input string tag);
    exp_t e;
    @(posedge clk); #1;
    dataIn = din; startReq = st;
    e.val = expOut; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compare at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checkEq(e.tag, dataOut, e.val);
    end
  end

  // Full run; start held high at cycle holdK to exercise R8
  task automatic runTest(input int holdK, input logic expectFltFail);
    logic [3:0] pat = 4'b0001;
    logic [15:0] seen = '0;
    drive(4'b1010, 1'b1, refF(4'b1010), "R2 start cycle");
    for (int k = 0; k < 15; k++) begin
      logic [3:0] din;
      din = 4'(k * 7 + 3);
      drive(din, (k == holdK), refF(pat), (k == 0) ? "R3 first pattern" : "R4 pattern step");
      seen[pat] = 1'b1;
      @(negedge clk);
      checkEq("R5 done low during run", doneFlag, 0);
      checkEq("R6 clean cone no fail", failFlag, 0);
      if (k == 0) begin
        checkEq("R7 new run clears fail", failF, 0);
        checkEq("R7 new run clears done", doneF, 0);
      end
      if (k == 1) checkEq("R9 no fail before first mismatch registers", failF, 0);
      if (k == 2) checkEq("R9 fail rises after mismatch", failF, 1);
      pat = refNext(pat);
    end
    checkEq("R4 all nonzero patterns visited", int'(seen), 16'hFFFE);
    drive(4'b0110, 1'b0, refF(4'b0110), "R5 back to normal mode");
    @(negedge clk);
    checkEq("R5 done after 15 patterns", doneFlag, 1);
    checkEq("R6 fault detected", failF, int'(expectFltFail));
    checkEq("R6 clean still passes", failFlag, 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 3);
    checkEq("R1 done in reset", doneFlag, 0);
    checkEq("R1 fail in reset", failFlag, 0);
    checkEq("R1 normal mode in reset", dataOut, refF(dataIn));
    @(posedge clk); #1 rstN = 1'b1;
    // R2: normal mode across patterns
    for (int v = 0; v < 16; v += 5) drive(4'(v), 1'b0, refF(4'(v)), "R2 normal mode");
    drive(4'hF, 1'b0, refF(4'hF), "R2 normal all ones");
    @(negedge clk);
    checkEq("R1 done after reset", doneFlag, 0);
    checkEq("R1 fail after reset", failFlag, 0);
    // First run, start request repeated at cycle 5 (R8)
    runTest(5, 1'b1);
    // R7: fail stays set through idle cycles
    for (int i = 0; i < 3; i++) drive(4'(i), 1'b0, refF(4'(i)), "R2 idle after run");
    @(negedge clk);
    checkEq("R7 fail sticky while idle", failF, 1);
    checkEq("R7 done held while idle", doneF, 1);
    // Second run clears and re-detects
    runTest(100, 1'b1);
    // Reset clears sticky flags
    @(posedge clk); #1 rstN = 1'b0;
    @(negedge clk);
    checkEq("R1 reset clears fail", failF, 0);
    checkEq("R1 reset clears done", doneF, 0);
    @(posedge clk); #1 rstN = 1'b1;
    drive(4'b1101, 1'b0, refF(4'b1101), "R2 normal after reset");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule